// File: doc/BRIEF.md
# Codirectional Octet Line Encoder

This block takes one octet per frame from a 2.048 MHz serial PCM bus and sends it as a 64 kbps codirectional line code. The octet is read during a time-slot chosen from two strobes by a select pin. It then crosses into a free-running 256 kHz output domain, where each bit becomes four unit intervals on one of two active-low rails. Consecutive blocks alternate rails. The eighth block of every octet repeats the rail of the seventh, and that violation marks the end of the octet.

The two clocks are unrelated, so the output side consumes octets at its own pace. A newer octet replaces one that is still waiting. If the output runs out of data, it resends the last octet once and then falls silent. The alarm input suppresses the octet-marking violation, so a far end can detect that octet timing is lost. The block is used as the digital half of a codirectional port, with an external line driver attached to the two rails.

Top module: `codir_octet_encoder`

## Requirements
- R1: The strobe is picked by `slot_sel`: 1 uses `slot_a` and 0 uses `slot_b`. Pulses on the strobe not picked change nothing on the rails.
- R2: Bits are captured on rising `pcm_clk` edges while the picked strobe is high. The first bit captured is the octet's most significant bit and is sent first.
- R3: An octet moves to the output only after all eight blocks of the previous octet are out. Octets taken in sequence follow each other with no idle unit interval between them.
- R4: An octet that completes while an earlier one is still waiting replaces the waiting one. The replaced octet is never sent.
- R5: At an octet boundary with no new octet waiting, the last octet is sent one more time. After that both rails stay high until a new octet arrives.
- R6: Each bit takes four `line_clk` unit intervals on one rail, with the other rail high. At the pins (low = pulse), a 1 reads 0,0,1,1 and a 0 reads 0,1,0,1 in time order.
- R7: Every block that is not an octet's eighth uses the rail opposite to the block sent just before it. This holds across octet boundaries and across idle gaps.
- R8: With `alarm` low, the eighth block of an octet uses the same rail as the seventh.
- R9: With `alarm` high, the eighth block also alternates. `alarm` is sampled at the `line_clk` edge that begins the eighth block.
- R10: During and after reset both rails are high. The first block after reset goes out on the positive rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pcm_clk | input | 1 | 2.048 MHz PCM bit clock |
| pcm_data | input | 1 | Serial PCM data |
| slot_a | input | 1 | Time-slot strobe used when `slot_sel` is 1 |
| slot_b | input | 1 | Time-slot strobe used when `slot_sel` is 0 |
| slot_sel | input | 1 | Strobe select |
| line_clk | input | 1 | 256 kHz unit-interval clock |
| alarm | input | 1 | High suppresses the octet-marking violation |
| rail_pos_n | output | 1 | Positive rail, active low |
| rail_neg_n | output | 1 | Negative rail, active low |

## Verification
The bench decodes the rails into blocks, recording the rail, the bit value and whether the block followed an idle gap, and compares them with an independent model of rail alternation.

- Octets with mixed bit patterns (0xA5, 0x3C, 0x0F) separate the two unit-interval codes and expose bit-order errors.
- Sending with each strobe-select setting, including pulses on the strobe that is not picked, checks strobe selection.
- Runs with the alarm high and low separate a violation from strict alternation on the eighth block.
- A back-to-back pair of octets sent while the output is busy separates overwriting from queueing.
- Letting the source go quiet shows the single repeat followed by silence.

// File: rtl/codir_pkg.sv
`timescale 1ns/1ps
package codir_pkg;

    // Rail carrying the current 4-UI block
    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

    function automatic pol_e pol_flip(input pol_e p);
        return (p == POL_POS) ? POL_NEG : POL_POS;
    endfunction

endpackage

// File: rtl/codir_sync2.sv
`timescale 1ns/1ps
module codir_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/codir_capture.sv
`timescale 1ns/1ps
module codir_capture #(
    parameter int unsigned OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcm_data,
    input  logic             slot_a,
    input  logic             slot_b,
    input  logic             slot_sel,
    input  logic             ack_sync,
    output logic [OCT_W-1:0] latch,
    output logic             req
);
    localparam int unsigned CNT_W = $clog2(OCT_W);

    typedef struct packed {
        logic [OCT_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
        logic [OCT_W-1:0] latch;
        logic             req;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    slot;
    logic    full;

    assign slot = slot_sel ? slot_a : slot_b;
    // Latch still waiting for the line side while req and ack differ
    assign full = st_q.req ^ ack_sync;

    always_comb begin
        st_d = st_q;
        if (slot) begin
            st_d.shreg = {st_q.shreg[OCT_W-2:0], pcm_data};
            if (st_q.cnt == CNT_W'(OCT_W-1)) begin
                st_d.cnt   = '0;
                st_d.latch = {st_q.shreg[OCT_W-2:0], pcm_data};
                // Overwrite in place when full; raise a new request otherwise
                if (!full) st_d.req = ~st_q.req;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
    assign req   = st_q.req;

    // R2: latch only ever changes right after the eighth strobed bit
    assert_latch_on_full_octet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch != $past(st_q.latch)) |-> $past(slot && st_q.cnt == CNT_W'(OCT_W-1)));

    // R4: a second request is never raised while one is outstanding
    assert_no_double_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req != $past(st_q.req)) |-> $past(!full));
endmodule

// File: rtl/codir_line_coder.sv
`timescale 1ns/1ps
module codir_line_coder
    import codir_pkg::*;
#(
    parameter int unsigned OCT_W = 8,
    parameter int unsigned UI_N  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alarm,
    input  logic [OCT_W-1:0] latch_in,
    input  logic             req_sync,
    output logic             ack,
    output logic             rail_pos_n,
    output logic             rail_neg_n
);
    localparam int unsigned CNT_W = $clog2(OCT_W);
    localparam int unsigned UI_W  = $clog2(UI_N);

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [CNT_W-1:0] bitn;
        logic [UI_W-1:0]  ui;
        logic             busy;
        logic             spare;
        pol_e             pol;
        logic             ack;
    } line_st_t;

    // Polarity starts on the negative rail so the first block flips to positive
    localparam line_st_t RST_ST = '{oct: '0, bitn: '0, ui: '0, busy: 1'b0,
                                    spare: 1'b0, pol: POL_NEG, ack: 1'b0};

    line_st_t st_d, st_q;
    logic     pending;
    logic     last_ui;
    logic     last_bit;
    logic     boundary;
    logic     cur_bit;
    logic     mark;

    assign pending  = req_sync ^ st_q.ack;
    assign last_ui  = (st_q.ui == UI_W'(UI_N-1));
    assign last_bit = (st_q.bitn == CNT_W'(OCT_W-1));
    assign boundary = !st_q.busy || (last_ui && last_bit);

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.bitn = '0;
            st_d.ui   = '0;
            if (pending) begin
                st_d.oct   = latch_in;
                st_d.ack   = req_sync;
                st_d.busy  = 1'b1;
                st_d.spare = 1'b1;
                st_d.pol   = pol_flip(st_q.pol);
            end else if (st_q.busy && st_q.spare) begin
                st_d.spare = 1'b0;
                st_d.pol   = pol_flip(st_q.pol);
            end else begin
                st_d.busy = 1'b0;
            end
        end else if (last_ui) begin
            st_d.ui   = '0;
            st_d.bitn = st_q.bitn + 1'b1;
            if (st_q.bitn == CNT_W'(OCT_W-2) && !alarm) st_d.pol = st_q.pol;
            else                                       st_d.pol = pol_flip(st_q.pol);
        end else begin
            st_d.ui = st_q.ui + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    // Logical pattern: one = pulse in the first half, zero = pulse on even UIs
    assign cur_bit    = st_q.oct[CNT_W'(OCT_W-1) - st_q.bitn];
    assign mark       = st_q.busy && (cur_bit ? (st_q.ui < UI_W'(UI_N/2)) : !st_q.ui[0]);
    assign rail_pos_n = !(mark && st_q.pol == POL_POS);
    assign rail_neg_n = !(mark && st_q.pol == POL_NEG);
    assign ack        = st_q.ack;

    // R6: the two rails are never pulsed together
    assert_rails_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rail_pos_n && !rail_neg_n));

    // R3: the latch is only taken at an octet boundary with a request waiting
    assert_take_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ack != $past(st_q.ack)) |-> $past(boundary && pending));

    // R5: a boundary with no data and the repeat already used goes idle
    assert_single_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last_ui && last_bit && !pending && !st_q.spare) |=> !st_q.busy);

    // R8: eighth block keeps the seventh block's rail when alarm is low
    assert_octet_violation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last_ui && st_q.bitn == CNT_W'(OCT_W-2) && !alarm)
        |=> (st_q.pol == $past(st_q.pol)));

    // R7: inner blocks always alternate rails
    assert_inner_alternation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last_ui && !last_bit && st_q.bitn != CNT_W'(OCT_W-2))
        |=> (st_q.pol != $past(st_q.pol)));
endmodule

// File: rtl/codir_octet_encoder.sv
`timescale 1ns/1ps
module codir_octet_encoder #(
    parameter int unsigned OCT_W = 8,
    parameter int unsigned UI_N  = 4
) (
    input  logic rst_n,
    input  logic pcm_clk,
    input  logic pcm_data,
    input  logic slot_a,
    input  logic slot_b,
    input  logic slot_sel,
    input  logic line_clk,
    input  logic alarm,
    output logic rail_pos_n,
    output logic rail_neg_n
);
    logic [OCT_W-1:0] latch;
    logic             req;
    logic             req_sync;
    logic             ack;
    logic             ack_sync;

    codir_capture #(.OCT_W(OCT_W)) u_capture (
        .clk      (pcm_clk),
        .rst_n    (rst_n),
        .pcm_data (pcm_data),
        .slot_a   (slot_a),
        .slot_b   (slot_b),
        .slot_sel (slot_sel),
        .ack_sync (ack_sync),
        .latch    (latch),
        .req      (req)
    );

    codir_sync2 #(.STAGES(2)) u_req_sync (
        .clk   (line_clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_sync)
    );

    codir_sync2 #(.STAGES(2)) u_ack_sync (
        .clk   (pcm_clk),
        .rst_n (rst_n),
        .d     (ack),
        .q     (ack_sync)
    );

    codir_line_coder #(.OCT_W(OCT_W), .UI_N(UI_N)) u_coder (
        .clk        (line_clk),
        .rst_n      (rst_n),
        .alarm      (alarm),
        .latch_in   (latch),
        .req_sync   (req_sync),
        .ack        (ack),
        .rail_pos_n (rail_pos_n),
        .rail_neg_n (rail_neg_n)
    );
endmodule

// File: tb/test_codir_octet_encoder.sv
`timescale 1ns/1ps
module test_codir_octet_encoder;
    logic pcm_clk  = 1'b0;
    logic line_clk = 1'b0;
    logic rst_n    = 1'b0;
    logic pcm_data = 1'b0;
    logic slot_a   = 1'b0;
    logic slot_b   = 1'b0;
    logic slot_sel = 1'b1;
    logic alarm    = 1'b0;
    logic rail_pos_n;
    logic rail_neg_n;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // block monitor state
    bit   blk_val   [512];
    bit   blk_pol   [512];
    bit   blk_ok    [512];
    bit   blk_start [512];
    int   nb    = 0;
    int   phase = 0;
    bit   gap   = 1;
    logic [3:0] up = '1;
    logic [3:0] un = '1;
    int   exp_pol = 1;   // rail of the last block, 0 = positive

    always #10 pcm_clk  = ~pcm_clk;    // 50 MHz
    always #80 line_clk = ~line_clk;   // eight PCM clocks per UI

    codir_octet_encoder i_codir_octet_encoder (
        .rst_n      (rst_n),
        .pcm_clk    (pcm_clk),
        .pcm_data   (pcm_data),
        .slot_a     (slot_a),
        .slot_b     (slot_b),
        .slot_sel   (slot_sel),
        .line_clk   (line_clk),
        .alarm      (alarm),
        .rail_pos_n (rail_pos_n),
        .rail_neg_n (rail_neg_n)
    );

    // Decode the rails into 4-UI blocks, sampled between line edges
    always @(negedge line_clk) begin
        if (!rst_n) begin
            phase = 0;
            gap   = 1;
        end else if (phase == 0 && rail_pos_n && rail_neg_n) begin
            gap = 1;
        end else begin
            up = {up[2:0], rail_pos_n};
            un = {un[2:0], rail_neg_n};
            phase++;
            if (phase == 4) begin
                if (nb < 512) begin
                    blk_start[nb] = gap;
                    blk_ok[nb]    = 1'b1;
                    if (un == 4'hF && (up == 4'b0011 || up == 4'b0101)) begin
                        blk_pol[nb] = 1'b0;
                        blk_val[nb] = (up == 4'b0011);
                    end else if (up == 4'hF && (un == 4'b0011 || un == 4'b0101)) begin
                        blk_pol[nb] = 1'b1;
                        blk_val[nb] = (un == 4'b0011);
                    end else begin
                        blk_ok[nb] = 1'b0;
                    end
                    nb++;
                end
                gap   = 0;
                phase = 0;
            end
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_octet(input logic [7:0] v, input bit use_b);
        @(negedge pcm_clk);
        for (int i = 0; i < 8; i++) begin
            if (use_b) slot_b = 1'b1; else slot_a = 1'b1;
            pcm_data = v[7-i];
            @(negedge pcm_clk);
        end
        slot_a   = 1'b0;
        slot_b   = 1'b0;
        pcm_data = 1'b0;
    endtask

    task automatic check_octet(input int base, input logic [7:0] v, input bit exp_start,
                               input bit alm, input string rv, input string rp);
        logic [7:0] av, ap, ep;
        bit allok = 1;
        int p = exp_pol;
        for (int i = 0; i < 8; i++) begin
            av[7-i] = blk_val[base+i];
            ap[7-i] = blk_pol[base+i];
            if (!blk_ok[base+i]) allok = 0;
            p = (i == 7 && !alm) ? p : 1 - p;
            ep[7-i] = p[0];
        end
        exp_pol = p;
        check(av == v, rv, "octet value", av, v);
        check(allok, "R6", "unit interval pattern", allok, 1);
        check(ap == ep, rp, "block rails", ap, ep);
        check(blk_start[base] == exp_start, "R3", "gap before octet", blk_start[base], exp_start);
    endtask

    task automatic t_reset();
        #400;
        @(negedge line_clk);
        check(rail_pos_n && rail_neg_n, "R10", "rails after reset",
              {rail_pos_n, rail_neg_n}, 2'b11);
        check(nb == 0, "R10", "no blocks after reset", nb, 0);
    endtask

    task automatic t_basic();
        int base = nb;
        slot_sel = 1'b1;
        send_octet(8'hA5, 1'b0);
        #20000;
        check(nb == base + 16, "R5", "one octet plus one repeat", nb - base, 16);
        check(blk_pol[base] == 1'b0, "R10", "first block on positive rail", blk_pol[base], 0);
        check_octet(base, 8'hA5, 1'b1, 1'b0, "R2", "R8");
        check_octet(base + 8, 8'hA5, 1'b0, 1'b0, "R5", "R7");
        @(negedge line_clk);
        check(rail_pos_n && rail_neg_n, "R5", "rails idle after repeat",
              {rail_pos_n, rail_neg_n}, 2'b11);
    endtask

    task automatic t_select();
        int base = nb;
        slot_sel = 1'b1;
        send_octet(8'h3C, 1'b1);      // strobe not picked
        slot_sel = 1'b0;
        send_octet(8'hC3, 1'b0);      // strobe not picked
        #3000;
        check(nb == base, "R1", "unpicked strobes ignored", nb - base, 0);
        send_octet(8'h3C, 1'b1);
        #20000;
        check(nb == base + 16, "R1", "picked strobe b sends", nb - base, 16);
        check_octet(base, 8'h3C, 1'b1, 1'b0, "R1", "R7");
        check_octet(base + 8, 8'h3C, 1'b0, 1'b0, "R5", "R8");
    endtask

    task automatic t_alarm();
        int base = nb;
        slot_sel = 1'b1;
        alarm    = 1'b1;
        send_octet(8'h0F, 1'b0);
        #20000;
        check(nb == base + 16, "R9", "octets under alarm", nb - base, 16);
        check_octet(base, 8'h0F, 1'b1, 1'b1, "R2", "R9");
        check_octet(base + 8, 8'h0F, 1'b0, 1'b1, "R5", "R9");
        alarm = 1'b0;
    endtask

    task automatic t_overwrite();
        int base = nb;
        slot_sel = 1'b1;
        send_octet(8'h81, 1'b0);
        #1500;                         // first octet is now on the line
        send_octet(8'h42, 1'b0);
        send_octet(8'h99, 1'b0);       // replaces the waiting 0x42
        #20000;
        check(nb == base + 24, "R4", "three octets after overwrite", nb - base, 24);
        check_octet(base, 8'h81, 1'b1, 1'b0, "R3", "R8");
        check_octet(base + 8, 8'h99, 1'b0, 1'b0, "R4", "R7");
        check_octet(base + 16, 8'h99, 1'b0, 1'b0, "R5", "R8");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #305;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_select();
        t_alarm();
        t_overwrite();
        finish_run();
    end

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        finish_run();
    end
endmodule